// File: doc/BRIEF.md
# Card Socket Present-State Status Register

This block produces the 32-bit read value of a socket status register in a removable-card host controller. It merges three kinds of information. The first is the supply levels the socket itself can provide. The second is the supply levels the inserted card says it accepts. The third is two sticky error flags. It also passes the raw low status byte through unchanged. The register is read-only: software changes it only through a companion force-event register, whose write strobe and data fields arrive on dedicated ports.

A small state machine follows the socket. It has three states:

- `SK_EMPTY`: no card. The transition EMPTY→IDENT fires when card detect goes to 1.
- `SK_IDENT`: identification is running. The state holds while `ident_busy` is 1, whatever card detect does. The transition IDENT→PRESENT fires when `ident_busy` is 0. That transition is the single capture point: the card's voltage-sense inputs are latched and the sticky flags are cleared.
- `SK_PRESENT`: card inserted. The transition PRESENT→EMPTY fires when card detect returns to 0. The latched card fields keep their values until the next capture.

The sticky flags have their own reset domain. While power management is enabled, only the global reset clears them. Otherwise either reset clears them. All other state is cleared by either reset. All resets are synchronous and active low.

Top module: `sock_state_reg`

## Requirements
- R1: While either reset is held, and on the first read after it, the register shows bits 31:30 = 00, bit 29 = 1, bits 13:10 = 0000 and bits 9:8 = 00.
- R2: A write strobe on `force_wr` loads `force_sock_data[2:0]` into bits 31:29 (index 2 → bit 31, index 0 → bit 29), visible on the read value from the clock after the strobe. Writing 0 to index 0 withdraws 3.3 V support, and writing 1 to indices 2 and 1 sets the two unassigned levels.
- R3: Bit 28 equals the inverse of `dev_5v_off`, with no clock delay.
- R4: Bits 27:14 read 0 under every input pattern, including an all-ones force write.
- R5: On the IDENT→PRESENT transition, `vsense[3:0]` is captured into bits 13:10 (index 3 → bit 13, unassigned Y; index 2 → bit 12, unassigned X; index 1 → bit 11, 3.3 V; index 0 → bit 10, 5 V). Changes of `vsense` at any other time do not alter these bits.
- R6: A force write ORs `force_card_data[3:0]` into bits 13:10 on the clock after the strobe. A 0 in a position leaves that bit unchanged.
- R7: The state machine leaves IDENT only when `ident_busy` is 0. Toggling card detect during identification changes neither the state path nor bits 13:10.
- R8: A 1 on `bad_vcc_evt` sets bit 9, and a 1 on `data_lost_evt` sets bit 8, from the next clock.
- R9: Bits 9:8 hold once set until their reset or until the next IDENT→PRESENT transition clears them. An event in the same cycle as that transition wins and leaves its bit set.
- R10: With `pme_en` = 1, a primary reset alone leaves bits 9:8 unchanged while it still clears the other state. A global reset clears bits 9:8.
- R11: With `pme_en` = 0, a primary reset clears bits 9:8.
- R12: Bits 7:0 equal `low_status[7:0]` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| prst_n | input | 1 | Primary reset, active low, synchronous |
| grst_n | input | 1 | Global reset, active low, synchronous |
| pme_en | input | 1 | Power management enabled; selects the sticky reset domain |
| card_detect | input | 1 | Card-detect result, 1 = card present |
| ident_busy | input | 1 | Card identification in progress |
| vsense | input | 4 | Card voltage-sense results, Y/X/3.3 V/5 V from index 3 to 0 |
| force_wr | input | 1 | Force-event register write strobe |
| force_sock_data | input | 3 | Write data for socket capability bits 31:29 |
| force_card_data | input | 4 | Write data for card capability bits 13:10 |
| dev_5v_off | input | 1 | Device-control override that withdraws 5 V socket support |
| bad_vcc_evt | input | 1 | Invalid supply request event |
| data_lost_evt | input | 1 | Possible data loss on removal event |
| low_status | input | 8 | Raw socket status, passed to bits 7:0 |
| rd_data | output | 32 | Register read value |

## Verification
The bench toggles card detect and the sense inputs in the middle of identification and confirms that the card field still takes the sense value present on the exit cycle. A design that captured on the insertion edge, or one that restarted on detect bounces, would show stale or zero card bits. It fires a bad-supply event in the same cycle as a capture, where a design that let the clear win would lose the flag. It also checks a primary reset with power management on and then off: a design that used a single reset domain would wipe or keep the sticky flags in the wrong case, and one that kept forced socket bits across reset would miss the 3000_00xxh pattern.

// File: rtl/sock_state_pkg.sv
package sock_state_pkg;

    typedef enum logic [1:0] {
        SK_EMPTY   = 2'd0,
        SK_IDENT   = 2'd1,
        SK_PRESENT = 2'd2
    } sock_st_e;

    localparam int SOCK_W    = 3;
    localparam logic [SOCK_W-1:0] SOCK_RST = 3'b001;

endpackage

// File: rtl/sock_fsm.sv
module sock_fsm
    import sock_state_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic card_detect,
    input  logic ident_busy,
    output logic cap_pulse
);

    sock_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SK_EMPTY;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        cap_pulse = 1'b0;
        unique case (state_q)
            SK_EMPTY: begin
                if (card_detect) state_d = SK_IDENT;
            end
            SK_IDENT: begin
                if (!ident_busy) begin
                    state_d   = SK_PRESENT;
                    cap_pulse = 1'b1;
                end
            end
            SK_PRESENT: begin
                if (!card_detect) state_d = SK_EMPTY;
            end
            default: state_d = SK_EMPTY;
        endcase
    end

    // R7: identification is never cut short while busy
    p_ident_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == SK_IDENT && ident_busy) |=> (state_q == SK_IDENT));

endmodule

// File: rtl/sock_cap_regs.sv
module sock_cap_regs
    import sock_state_pkg::*;
#(
    parameter int CV_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_pulse,
    input  logic [CV_W-1:0]   vsense,
    input  logic              force_wr,
    input  logic [SOCK_W-1:0] force_sock,
    input  logic [CV_W-1:0]   force_card,
    output logic [SOCK_W-1:0] sock_bits,
    output logic [CV_W-1:0]   card_bits
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sock_bits <= SOCK_RST;
        end else if (force_wr) begin
            sock_bits <= force_sock;
        end
    end

    logic [CV_W-1:0] card_base;
    logic [CV_W-1:0] card_or;

    always_comb begin
        card_base = cap_pulse ? vsense : card_bits;
        card_or   = force_wr ? force_card : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) card_bits <= '0;
        else     card_bits <= card_base | card_or;
    end

    // R2: socket bits follow the last force write
    p_sock_load_r2: assert property (@(posedge clk) disable iff (rst)
        force_wr |=> (sock_bits == $past(force_sock)));

    // R6: forced card bits are set after the write
    p_force_card_r6: assert property (@(posedge clk) disable iff (rst)
        force_wr |=> ((card_bits & $past(force_card)) == $past(force_card)));

    // R5: card field moves only on a capture or a force write
    p_card_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (!cap_pulse && !force_wr) |=> $stable(card_bits));

endmodule

// File: rtl/sock_sticky.sv
module sock_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_sticky,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst_sticky)  q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr)    q[i] <= 1'b0;
        end

        // R8: an event sets its flag by the next clock
        p_set_r8: assert property (@(posedge clk) disable iff (rst_sticky)
            set[i] |=> q[i]);

        // R9: a set flag survives until cleared or reset
        p_hold_r9: assert property (@(posedge clk) disable iff (rst_sticky)
            (q[i] && !clr) |=> q[i]);
    end

endmodule

// File: rtl/sock_state_reg.sv
module sock_state_reg
    import sock_state_pkg::*;
#(
    parameter int CV_W  = 4,
    parameter int ST_W  = 2,
    parameter int LOW_W = 8
) (
    input  logic              clk,
    input  logic              prst_n,
    input  logic              grst_n,
    input  logic              pme_en,
    input  logic              card_detect,
    input  logic              ident_busy,
    input  logic [CV_W-1:0]   vsense,
    input  logic              force_wr,
    input  logic [SOCK_W-1:0] force_sock_data,
    input  logic [CV_W-1:0]   force_card_data,
    input  logic              dev_5v_off,
    input  logic              bad_vcc_evt,
    input  logic              data_lost_evt,
    input  logic [LOW_W-1:0]  low_status,
    output logic [31:0]       rd_data
);

    localparam int RSVD_W = 32 - SOCK_W - 1 - CV_W - ST_W - LOW_W;

    logic rst_all;
    logic rst_sticky;
    logic cap_pulse;
    logic [SOCK_W-1:0] sock_bits;
    logic [CV_W-1:0]   card_bits;
    logic [ST_W-1:0]   sticky_q;

    always_comb begin
        rst_all    = !prst_n || !grst_n;
        rst_sticky = !grst_n || (!prst_n && !pme_en);
    end

    sock_fsm u_fsm (
        .clk         (clk),
        .rst         (rst_all),
        .card_detect (card_detect),
        .ident_busy  (ident_busy),
        .cap_pulse   (cap_pulse)
    );

    sock_cap_regs #(.CV_W(CV_W)) u_cap (
        .clk        (clk),
        .rst        (rst_all),
        .cap_pulse  (cap_pulse),
        .vsense     (vsense),
        .force_wr   (force_wr),
        .force_sock (force_sock_data),
        .force_card (force_card_data),
        .sock_bits  (sock_bits),
        .card_bits  (card_bits)
    );

    sock_sticky #(.N(ST_W)) u_sticky (
        .clk        (clk),
        .rst_sticky (rst_sticky),
        .clr        (cap_pulse),
        .set        ({bad_vcc_evt, data_lost_evt}),
        .q          (sticky_q)
    );

    always_comb begin
        rd_data = {sock_bits, ~dev_5v_off, {RSVD_W{1'b0}},
                   card_bits, sticky_q, low_status};
    end

endmodule

// File: tb/sock_state_reg_test.sv
module sock_state_reg_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        prst_n, grst_n, pme_en, card_detect, ident_busy;
    logic [3:0]  vsense;
    logic        force_wr;
    logic [2:0]  force_sock_data;
    logic [3:0]  force_card_data;
    logic        dev_5v_off, bad_vcc_evt, data_lost_evt;
    logic [7:0]  low_status;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sock_state_reg uut (
        .clk(clk), .prst_n(prst_n), .grst_n(grst_n), .pme_en(pme_en),
        .card_detect(card_detect), .ident_busy(ident_busy), .vsense(vsense),
        .force_wr(force_wr), .force_sock_data(force_sock_data),
        .force_card_data(force_card_data), .dev_5v_off(dev_5v_off),
        .bad_vcc_evt(bad_vcc_evt), .data_lost_evt(data_lost_evt),
        .low_status(low_status), .rd_data(rd_data)
    );

    function automatic logic [31:0] word(input logic [2:0] s, input logic v5off,
                                         input logic [3:0] c, input logic [1:0] st,
                                         input logic [7:0] lo);
        return {s, ~v5off, 14'b0, c, st, lo};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic drive_edge;
        @(negedge clk);
    endtask

    task automatic do_reset(input bit prim, input bit glob);
        drive_edge();
        prst_n = !prim; grst_n = !glob;
        tick(); tick();
        drive_edge();
        prst_n = 1'b1; grst_n = 1'b1;
        tick();
    endtask

    task automatic do_force(input logic [2:0] s, input logic [3:0] c);
        drive_edge();
        force_wr = 1'b1; force_sock_data = s; force_card_data = c;
        tick();
        drive_edge();
        force_wr = 1'b0; force_sock_data = 3'b000; force_card_data = 4'b0000;
    endtask

    task automatic do_insert(input logic [3:0] vs);
        drive_edge();
        card_detect = 1'b1; ident_busy = 1'b1;
        tick(); tick();
        drive_edge();
        vsense = vs; ident_busy = 1'b0;
        tick();
        drive_edge();
        vsense = 4'b0000;
    endtask

    task automatic do_remove;
        drive_edge();
        card_detect = 1'b0;
        tick();
    endtask

    task automatic t_reset;
        do_reset(1'b1, 1'b1);
        #1 check("R1 reset value", rd_data, word(3'b001, 1'b0, 4'h0, 2'b00, 8'h00));
    endtask

    task automatic t_low_and_5v;
        drive_edge();
        low_status = 8'hA5; #1;
        check("R12 low byte", rd_data[7:0], 8'hA5);
        low_status = 8'h3C; dev_5v_off = 1'b1; #1;
        check("R12 low byte second", rd_data[7:0], 8'h3C);
        check("R3 5V withdrawn", {31'b0, rd_data[28]}, 32'd0);
        dev_5v_off = 1'b0; #1;
        check("R3 5V restored", {31'b0, rd_data[28]}, 32'd1);
        low_status = 8'h00;
    endtask

    task automatic t_force_sock;
        do_force(3'b110, 4'b0000);
        #1 check("R2 socket forced", rd_data, word(3'b110, 1'b0, 4'h0, 2'b00, 8'h00));
        do_force(3'b111, 4'b1111);
        #1 check("R4 reserved zero", {18'b0, rd_data[27:14]}, 32'd0);
        check("R2 socket all ones", {29'b0, rd_data[31:29]}, 32'd7);
        do_force(3'b001, 4'b0000);
        #1 check("R2 socket back", {29'b0, rd_data[31:29]}, 32'd1);
        check("R6 zeros leave card bits", {28'b0, rd_data[13:10]}, 32'hF);
        do_reset(1'b1, 1'b0);
    endtask

    task automatic t_insert;
        // vsense changes while empty are ignored (R5)
        drive_edge();
        vsense = 4'b1111;
        tick(); tick();
        check("R5 sense ignored when empty", {28'b0, rd_data[13:10]}, 32'h0);
        drive_edge();
        vsense = 4'b0000;
        // insertion with detect bounce during identification (R7)
        drive_edge();
        card_detect = 1'b1; ident_busy = 1'b1;
        tick();
        drive_edge();
        card_detect = 1'b0; vsense = 4'b0110;
        tick(); tick();
        drive_edge();
        card_detect = 1'b1;
        tick();
        check("R7 frozen during ident", {28'b0, rd_data[13:10]}, 32'h0);
        drive_edge();
        vsense = 4'b1010; ident_busy = 1'b0;
        tick();
        drive_edge();
        vsense = 4'b0101;
        tick();
        check("R5 captured at ident end", {28'b0, rd_data[13:10]}, 32'hA);
        check("R5 later sense ignored", {28'b0, rd_data[13:10]}, 32'hA);
        do_force(3'b001, 4'b0001);
        #1 check("R6 force ORs card bit", {28'b0, rd_data[13:10]}, 32'hB);
        do_remove();
        check("R5 bits kept after removal", {28'b0, rd_data[13:10]}, 32'hB);
        do_insert(4'b0011);
        #1 check("R5 recaptured", {28'b0, rd_data[13:10]}, 32'h3);
        do_remove();
    endtask

    task automatic t_sticky;
        drive_edge();
        bad_vcc_evt = 1'b1;
        tick();
        drive_edge();
        bad_vcc_evt = 1'b0;
        #1 check("R8 bad supply flag", {30'b0, rd_data[9:8]}, 32'd2);
        data_lost_evt = 1'b1;
        tick();
        drive_edge();
        data_lost_evt = 1'b0;
        tick(); tick(); tick();
        check("R9 both flags held", {30'b0, rd_data[9:8]}, 32'd3);
        do_insert(4'b0001);
        #1 check("R9 cleared by insertion", {30'b0, rd_data[9:8]}, 32'd0);
        do_remove();
        // event in the capture cycle wins
        drive_edge();
        card_detect = 1'b1; ident_busy = 1'b1;
        tick();
        drive_edge();
        ident_busy = 1'b0; bad_vcc_evt = 1'b1;
        tick();
        drive_edge();
        bad_vcc_evt = 1'b0;
        #1 check("R9 event beats clear", {30'b0, rd_data[9:8]}, 32'd2);
        do_remove();
    endtask

    task automatic t_pme;
        drive_edge();
        pme_en = 1'b1; bad_vcc_evt = 1'b1; data_lost_evt = 1'b1;
        tick();
        drive_edge();
        bad_vcc_evt = 1'b0; data_lost_evt = 1'b0;
        do_force(3'b110, 4'b0100);
        do_reset(1'b1, 1'b0);
        #1 check("R10 sticky kept on primary", rd_data, word(3'b001, 1'b0, 4'h0, 2'b11, 8'h00));
        do_reset(1'b0, 1'b1);
        #1 check("R10 global clears sticky", {30'b0, rd_data[9:8]}, 32'd0);
        drive_edge();
        pme_en = 1'b0; data_lost_evt = 1'b1;
        tick();
        drive_edge();
        data_lost_evt = 1'b0;
        do_reset(1'b1, 1'b0);
        #1 check("R11 primary clears sticky", {30'b0, rd_data[9:8]}, 32'd0);
    endtask

    initial begin
        prst_n = 1'b0; grst_n = 1'b0; pme_en = 1'b0;
        card_detect = 1'b0; ident_busy = 1'b0; vsense = 4'b0000;
        force_wr = 1'b0; force_sock_data = 3'b000; force_card_data = 4'b0000;
        dev_5v_off = 1'b0; bad_vcc_evt = 1'b0; data_lost_evt = 1'b0;
        low_status = 8'h00;
        t_reset();
        t_low_and_5v();
        t_force_sock();
        t_insert();
        t_sticky();
        t_pme();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule